// File: doc/BRIEF.md
# Lockstep Lane Divergence Stack

This block steers control flow for a chunk of four lanes that share one instruction stream. It holds a mask with one bit per lane; only the lanes whose bit is set may write results. When a conditional branch arrives, each lane supplies one condition bit. If the active lanes disagree, the lanes that take the branch continue at the branch target, and the rest are parked on a last-in first-out stack together with the fall-through address at which they must resume.

A return event ends the sub-chunk that is running. If the stack holds an entry, that entry is popped and its mask and resume address become current. If the stack is empty, the whole chunk has finished and the block raises its done flag. If the active lanes all agree at a branch, only the program counter moves and the stack is left alone. If every lane goes its own way, the lanes end up running one after another.

Top module: `simd_diverge_stack`

## Requirements
- R1: While reset is low, and after it is released, the active mask is 0, the program counter output is 0 and the done flag is 1.
- R2: A start event loads the mask and PC given with it and empties the stack. The done flag goes to 0, unless the loaded mask is all zeros, in which case it stays 1. The new values appear one clock after the event.
- R3: A branch whose condition bit is 1 for every active lane sets the PC to the branch target, keeps the mask and pushes nothing. Condition bits of inactive lanes have no effect.
- R4: A branch whose condition bit is 0 for every active lane sets the PC to the fall-through address, keeps the mask and pushes nothing.
- R5: A branch that splits the active lanes sets the mask to the active lanes with condition 1 and the PC to the target. It pushes the active lanes with condition 0, together with the fall-through address.
- R6: A return while the stack holds entries pops the newest entry, loading both its mask and its PC.
- R7: A return while the stack is empty raises the done flag and clears the mask. The PC holds.
- R8: While the done flag is 1, branch and return events change nothing.
- R9: Splits may nest until each lane is alone. Up to three deferred entries come back in reverse push order, and the stack never overflows.
- R10: Event priority is start, then branch, then return. A lower-priority event in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Begin a new chunk |
| start_mask | input | 4 | Lanes active in the new chunk |
| start_pc | input | 16 | Entry address of the new chunk |
| branch_valid | input | 1 | Conditional branch event |
| branch_cond | input | 4 | Per-lane branch outcome, bit i for lane i |
| branch_target | input | 16 | Address taken by lanes with condition 1 |
| branch_fall_pc | input | 16 | Resume address for lanes with condition 0 |
| ret_valid | input | 1 | Current sub-chunk has reached its return point |
| active_mask | output | 4 | Lanes allowed to write back |
| next_pc | output | 16 | Address of the sub-chunk now running |
| chunk_done | output | 1 | Chunk finished, or no chunk loaded |

## Verification
The hardest state to reach from the ports is a full stack: three deferred entries, each holding one lane, with one lane still running. Reaching it needs a chain of three nested branches, each splitting exactly one lane away from the lanes that are still active. The vector table builds this chain. It then drains the stack with returns and checks that masks and addresses come back in reverse order before the final return ends the chunk. Separate directed steps cover branch and return in the same cycle, start together with a branch, and a start with an empty mask.

// File: rtl/simd_diverge_pkg.sv
package simd_diverge_pkg;

  typedef enum logic [1:0] {
    BR_NONE  = 2'd0,
    BR_TAKEN = 2'd1,
    BR_FALL  = 2'd2,
    BR_SPLIT = 2'd3
  } br_kind_e;

  // Classify a branch from whether any active lane goes each way.
  function automatic br_kind_e classify(input logic any_taken, input logic any_defer);
    br_kind_e k;
    if (any_taken && any_defer) k = BR_SPLIT;
    else if (any_taken)         k = BR_TAKEN;
    else if (any_defer)         k = BR_FALL;
    else                        k = BR_NONE;
    return k;
  endfunction

endpackage

// File: rtl/diverge_split.sv
module diverge_split
  import simd_diverge_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] taken_mask,
  output logic [LANES-1:0] defer_mask,
  output br_kind_e         kind
);
  always_comb begin
    taken_mask = cur_mask & cond;
    defer_mask = cur_mask & ~cond;
    kind       = classify(|taken_mask, |defer_mask);
  end
endmodule

// File: rtl/lane_mask_stack.sv
module lane_mask_stack #(
  parameter int WIDTH = 20,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] top,
  output logic             empty,
  output logic             full
);
  localparam int SPW = $clog2(DEPTH + 1);

  logic [SPW-1:0]   sp;
  logic [WIDTH-1:0] entries [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                           entries[i] <= '0;
      else if (push && !full && sp == SPW'(i)) entries[i] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)         sp <= '0;
    else if (push && !full)    sp <= sp + 1'b1;
    else if (pop && !empty)    sp <= sp - 1'b1;
  end

  assign empty = (sp == '0);
  assign full  = (sp == SPW'(DEPTH));
  assign top   = empty ? '0 : entries[sp - 1'b1];
endmodule

// File: rtl/simd_diverge_stack.sv
module simd_diverge_stack
  import simd_diverge_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PC_W  = 16,
  parameter int DEPTH = LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  logic [LANES-1:0] start_mask,
  input  logic [PC_W-1:0]  start_pc,
  input  logic             branch_valid,
  input  logic [LANES-1:0] branch_cond,
  input  logic [PC_W-1:0]  branch_target,
  input  logic [PC_W-1:0]  branch_fall_pc,
  input  logic             ret_valid,
  output logic [LANES-1:0] active_mask,
  output logic [PC_W-1:0]  next_pc,
  output logic             chunk_done
);
  localparam int ENT_W = LANES + PC_W;

  logic [LANES-1:0] mask_q;
  logic [PC_W-1:0]  pc_q;
  logic             done_q;

  logic [LANES-1:0] taken_mask, defer_mask;
  br_kind_e         kind;

  logic             ev_branch, ev_ret;
  logic             stk_push, stk_pop, stk_empty, stk_full, finish;
  logic [ENT_W-1:0] stk_top;

  diverge_split #(.LANES(LANES)) u_split (
    .cur_mask  (mask_q),
    .cond      (branch_cond),
    .taken_mask(taken_mask),
    .defer_mask(defer_mask),
    .kind      (kind)
  );

  // Priority: start over branch over return; done chunks ignore events.
  assign ev_branch = branch_valid && !start_valid && !done_q;
  assign ev_ret    = ret_valid && !branch_valid && !start_valid && !done_q;
  assign stk_push  = ev_branch && (kind == BR_SPLIT);
  assign stk_pop   = ev_ret && !stk_empty;
  assign finish    = ev_ret && stk_empty;

  lane_mask_stack #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_stack (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_valid),
    .push (stk_push),
    .pop  (stk_pop),
    .din  ({defer_mask, branch_fall_pc}),
    .top  (stk_top),
    .empty(stk_empty),
    .full (stk_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      pc_q   <= '0;
      done_q <= 1'b1;
    end else if (start_valid) begin
      mask_q <= start_mask;
      pc_q   <= start_pc;
      done_q <= (start_mask == '0);
    end else if (ev_branch) begin
      case (kind)
        BR_TAKEN: pc_q <= branch_target;
        BR_FALL:  pc_q <= branch_fall_pc;
        BR_SPLIT: begin
          mask_q <= taken_mask;
          pc_q   <= branch_target;
        end
        default: ;
      endcase
    end else if (stk_pop) begin
      mask_q <= stk_top[ENT_W-1:PC_W];
      pc_q   <= stk_top[PC_W-1:0];
    end else if (finish) begin
      mask_q <= '0;
      done_q <= 1'b1;
    end
  end

  assign active_mask = mask_q;
  assign next_pc     = pc_q;
  assign chunk_done  = done_q;
endmodule

// File: rtl/simd_diverge_stack_chk.sv
module simd_diverge_stack_chk #(
  parameter int LANES = 4,
  parameter int PC_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_valid,
  input logic             branch_valid,
  input logic [LANES-1:0] branch_cond,
  input logic [PC_W-1:0]  branch_target,
  input logic             ret_valid,
  input logic [LANES-1:0] active_mask,
  input logic [PC_W-1:0]  next_pc,
  input logic             chunk_done,
  input logic             stk_push,
  input logic             stk_full,
  input logic             stk_empty
);
  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |-> (active_mask == '0));

  assert_live_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !chunk_done |-> (active_mask != '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_push && stk_full));

  assert_ignored_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_done && !start_valid) |=>
      (chunk_done && $stable(active_mask) && $stable(next_pc)));

  assert_uniform_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_valid && !start_valid && !chunk_done &&
     ((branch_cond & active_mask) == active_mask)) |=>
      ($stable(active_mask) && next_pc == $past(branch_target)));

  assert_split_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_valid && !start_valid && !chunk_done &&
     ((branch_cond & active_mask) != '0) &&
     ((branch_cond & active_mask) != active_mask)) |=>
      (active_mask == $past(branch_cond & active_mask)));

  assert_pop_stays_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !branch_valid && !start_valid && !chunk_done && !stk_empty) |=>
      !chunk_done);
endmodule

bind simd_diverge_stack simd_diverge_stack_chk #(.LANES(LANES), .PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_valid  (start_valid),
  .branch_valid (branch_valid),
  .branch_cond  (branch_cond),
  .branch_target(branch_target),
  .ret_valid    (ret_valid),
  .active_mask  (active_mask),
  .next_pc      (next_pc),
  .chunk_done   (chunk_done),
  .stk_push     (stk_push),
  .stk_full     (stk_full),
  .stk_empty    (stk_empty)
);

// File: tb/simd_diverge_stack_test.sv
`timescale 1ns/1ps
module simd_diverge_stack_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_valid, branch_valid, ret_valid;
  logic [3:0]  start_mask, branch_cond;
  logic [15:0] start_pc, branch_target, branch_fall_pc;
  logic [3:0]  active_mask;
  logic [15:0] next_pc;
  logic        chunk_done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  simd_diverge_stack uut (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_mask(start_mask), .start_pc(start_pc),
    .branch_valid(branch_valid), .branch_cond(branch_cond),
    .branch_target(branch_target), .branch_fall_pc(branch_fall_pc),
    .ret_valid(ret_valid),
    .active_mask(active_mask), .next_pc(next_pc), .chunk_done(chunk_done)
  );

  // op: 0 start (cond=mask, tgt=pc), 1 branch, 2 return, 3 branch+return
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  cond;
    logic [15:0] tgt;
    logic [15:0] fall;
    logic [3:0]  em;
    logic [15:0] epc;
    logic        ed;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 4'b1111, 16'h0010, 16'h0000, 4'b1111, 16'h0010, 1'b0, 4'd2},  // R2
    '{2'd1, 4'b0011, 16'h0020, 16'h0011, 4'b0011, 16'h0020, 1'b0, 4'd5},  // R5
    '{2'd1, 4'b0001, 16'h0030, 16'h0021, 4'b0001, 16'h0030, 1'b0, 4'd5},  // R5
    '{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b0010, 16'h0021, 1'b0, 4'd6},  // R6
    '{2'd1, 4'b1111, 16'h0040, 16'h0022, 4'b0010, 16'h0040, 1'b0, 4'd3},  // R3
    '{2'd1, 4'b1101, 16'h0050, 16'h0041, 4'b0010, 16'h0041, 1'b0, 4'd4},  // R4
    '{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b1100, 16'h0011, 1'b0, 4'd6},  // R6
    '{2'd1, 4'b0100, 16'h0060, 16'h0012, 4'b0100, 16'h0060, 1'b0, 4'd5},  // R5
    '{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b1000, 16'h0012, 1'b0, 4'd6},  // R6
    '{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b0000, 16'h0012, 1'b1, 4'd7},  // R7
    '{2'd1, 4'b1111, 16'h0070, 16'h0071, 4'b0000, 16'h0012, 1'b1, 4'd8},  // R8
    '{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b0000, 16'h0012, 1'b1, 4'd8},  // R8
    '{2'd0, 4'b1111, 16'h0100, 16'h0000, 4'b1111, 16'h0100, 1'b0, 4'd2},  // R2
    '{2'd1, 4'b0111, 16'h0101, 16'h0200, 4'b0111, 16'h0101, 1'b0, 4'd9},  // R9
    '{2'd1, 4'b0011, 16'h0102, 16'h0201, 4'b0011, 16'h0102, 1'b0, 4'd9},  // R9
    '{2'd1, 4'b0001, 16'h0103, 16'h0202, 4'b0001, 16'h0103, 1'b0, 4'd9},  // R9
    '{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b0010, 16'h0202, 1'b0, 4'd9},  // R9
    '{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b0100, 16'h0201, 1'b0, 4'd9},  // R9
    '{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b1000, 16'h0200, 1'b0, 4'd9},  // R9
    '{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b0000, 16'h0200, 1'b1, 4'd7},  // R7
    '{2'd0, 4'b1111, 16'h0005, 16'h0000, 4'b1111, 16'h0005, 1'b0, 4'd2},  // R2
    '{2'd3, 4'b0011, 16'h0006, 16'h0007, 4'b0011, 16'h0006, 1'b0, 4'd10}, // R10
    '{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b1100, 16'h0007, 1'b0, 4'd6},  // R6
    '{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b0000, 16'h0007, 1'b1, 4'd7}   // R7
  };

  task automatic check(input int req, input logic [3:0] em, input logic [15:0] epc,
                       input logic ed);
    checks++;
    if (active_mask !== em || next_pc !== epc || chunk_done !== ed) begin
      errors++;
      $display("FAIL R%0d: mask=%b pc=%h done=%b expected mask=%b pc=%h done=%b",
               req, active_mask, next_pc, chunk_done, em, epc, ed);
    end
  endtask

  task automatic idle();
    start_valid = 0; branch_valid = 0; ret_valid = 0;
    start_mask = '0; start_pc = '0; branch_cond = '0;
    branch_target = '0; branch_fall_pc = '0;
  endtask

  // Inputs are applied at a falling edge, then checked one falling edge later.
  task automatic step(input vec_t v);
    start_valid  = (v.op == 2'd0);
    start_mask   = v.cond;
    start_pc     = v.tgt;
    branch_valid = (v.op == 2'd1) || (v.op == 2'd3);
    branch_cond  = v.cond;
    branch_target  = v.tgt;
    branch_fall_pc = v.fall;
    ret_valid    = (v.op == 2'd2) || (v.op == 2'd3);
    @(negedge clk);
    idle();
    check(int'(v.req), v.em, v.epc, v.ed);
  endtask

  initial begin
    for (int c = 0; c < 10000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(1, 4'b0000, 16'h0000, 1'b1);            // R1 during reset
    rst_n = 1;
    @(negedge clk);
    check(1, 4'b0000, 16'h0000, 1'b1);            // R1 after release

    for (int i = 0; i < NV; i++) step(TBL[i]);

    // R2: start with an empty mask leaves the chunk done
    step('{2'd0, 4'b0000, 16'h0033, 16'h0000, 4'b0000, 16'h0033, 1'b1, 4'd2});
    // R10: start wins over a branch in the same cycle
    start_valid = 1; start_mask = 4'b1010; start_pc = 16'h0009;
    branch_valid = 1; branch_cond = 4'b0000;
    branch_target = 16'h0001; branch_fall_pc = 16'h0002;
    @(negedge clk);
    idle();
    check(10, 4'b1010, 16'h0009, 1'b0);
    // R3: uniform taken pushes nothing, so one return ends the chunk
    step('{2'd1, 4'b1010, 16'h0044, 16'h0045, 4'b1010, 16'h0044, 1'b0, 4'd3});
    step('{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b0000, 16'h0044, 1'b1, 4'd3});
    // R4: uniform fall-through also pushes nothing
    step('{2'd0, 4'b0110, 16'h0080, 16'h0000, 4'b0110, 16'h0080, 1'b0, 4'd2});
    step('{2'd1, 4'b1001, 16'h0090, 16'h0081, 4'b0110, 16'h0081, 1'b0, 4'd4});
    step('{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b0000, 16'h0081, 1'b1, 4'd4});
    // R2: a start in mid-divergence empties the stack
    step('{2'd0, 4'b1111, 16'h00a0, 16'h0000, 4'b1111, 16'h00a0, 1'b0, 4'd2});
    step('{2'd1, 4'b0101, 16'h00a1, 16'h00b0, 4'b0101, 16'h00a1, 1'b0, 4'd5});
    step('{2'd0, 4'b0011, 16'h00c0, 16'h0000, 4'b0011, 16'h00c0, 1'b0, 4'd2});
    step('{2'd2, 4'b0000, 16'h0000, 16'h0000, 4'b0000, 16'h00c0, 1'b1, 4'd2});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule